// File: doc/BRIEF.md
# Split-Word Capture Memory Access Port

This block lets a processor with a 16-bit data path read and write a memory whose words are 32 bits wide. The processor sees four registers: an address, a low data half, a high data half and a small control register. The control register holds an auto-increment enable and the choice between two memories. Every access goes low half first and high half second. Writing the high half commits the whole 32-bit word to memory. Reading the high half completes a read. With auto-increment on, either high-half access also moves the address to the next location. The address wraps to zero after the last one.

Alongside the access port, the block packs live capture data into the same 32-bit word format. A pair of 20-bit I/Q samples becomes two 16-bit halves, I in the upper half and Q in the lower. The halves can be truncated or rounded with saturation. A 16-bit unsigned magnitude is split with its top bit alone in the upper half. The memory array and the capture sequencing sit outside this block.

Top module: `capmem_port`

## Requirements
- R1: After reset the address is 0, the control register is 0, no memory write is pending, memory 0 is selected and the held low half is 0. A high-half write issued before any low-half write therefore stores 0 in bits 15:0.
- R2: reg_sel picks the register: 0 address, 1 low half, 2 high half, 3 control (bit 0 auto-increment, bit 1 memory select). Reading sel 0 returns the address and reading sel 3 returns the two control bits. An address write of DEPTH or more loads 0.
- R3: A write to sel 2 raises mem_we for exactly one cycle, on the cycle after the write. It presents mem_waddr equal to the address and mem_wdata equal to {written data, held low half}. A write to any other register causes no memory write.
- R4: With auto-increment on, a high-half write or read moves the address to the next location in the cycle after the access. A low-half access never changes the address.
- R5: With auto-increment off, high-half accesses leave the address unchanged, so repeated accesses hit one location.
- R6: The address that follows DEPTH-1 is 0, and the address never reaches DEPTH.
- R7: Reading sel 1 returns bits 15:0 of the word at the current address. Reading sel 2 returns bits 31:16. A read never writes memory.
- R8: mem_sel follows control bit 1 and picks the memory that is both read and written.
- R9: In I/Q capture (cap_mag_mode=0) with cap_round=0, cap_word is {cap_i[19:4], cap_q[19:4]}.
- R10: With cap_round=1, each sample has 8 (one at bit 3) added before bits 19:4 are taken. A positive result that would overflow saturates to 16'h7FFF.
- R11: In magnitude capture (cap_mag_mode=1), cap_word is {15'b0, cap_mag[15], 1'b0, cap_mag[14:0]}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe, one cycle per access |
| reg_rd | input | 1 | Register read strobe, one cycle per access |
| reg_sel | input | 2 | Register select |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for the selected register |
| mem_raddr | output | AW | Memory read address |
| mem_rdata | input | 32 | Memory read data for mem_raddr in the selected memory |
| mem_we | output | 1 | Memory write pulse |
| mem_waddr | output | AW | Memory write address |
| mem_wdata | output | 32 | Memory write data |
| mem_sel | output | 1 | Selects memory 0 or 1 |
| cap_mag_mode | input | 1 | 1 packs magnitude, 0 packs I/Q |
| cap_round | input | 1 | Rounds I/Q samples when 1 |
| cap_i | input | SAMPLE_W | I sample, signed |
| cap_q | input | SAMPLE_W | Q sample, signed |
| cap_mag | input | 16 | Unsigned magnitude |
| cap_word | output | 32 | Packed capture word |

## Verification
The access port is exercised by a random mix of address loads, control changes and half-word reads and writes across both memories, with auto-increment both on and off. This shows whether the commit, the address step and the memory choice are tied to the correct half and mode. Directed sequences at the last location show wrap-around. An out-of-range address load shows clamping. A high-half write straight after reset shows the cleared low half. The packer is given random samples and also the values just below and at the positive limit and the most negative value. This separates truncation from rounding and exposes a missing saturation.

// File: rtl/capmem_port.sv
module capmem_port #(
  parameter int DEPTH    = 1000,
  parameter int SAMPLE_W = 20,
  parameter int AW       = $clog2(DEPTH)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_wr,
  input  logic                reg_rd,
  input  logic [1:0]          reg_sel,
  input  logic [15:0]         reg_wdata,
  output logic [15:0]         reg_rdata,
  output logic [AW-1:0]       mem_raddr,
  input  logic [31:0]         mem_rdata,
  output logic                mem_we,
  output logic [AW-1:0]       mem_waddr,
  output logic [31:0]         mem_wdata,
  output logic                mem_sel,
  input  logic                cap_mag_mode,
  input  logic                cap_round,
  input  logic [SAMPLE_W-1:0] cap_i,
  input  logic [SAMPLE_W-1:0] cap_q,
  input  logic [15:0]         cap_mag,
  output logic [31:0]         cap_word
);
  localparam int DROP = SAMPLE_W - 16;
  localparam logic [1:0] SEL_ADDR = 2'd0, SEL_LO = 2'd1, SEL_HI = 2'd2, SEL_CTL = 2'd3;

  logic [AW-1:0] addr_q;
  logic [15:0]   low_q;
  logic [1:0]    ctrl_q;

  wire autoinc = ctrl_q[0];
  wire hi_acc  = (reg_wr || reg_rd) && reg_sel == SEL_HI;
  wire [AW-1:0] addr_nx = (addr_q == AW'(DEPTH - 1)) ? '0 : addr_q + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q    <= '0;
      low_q     <= '0;
      ctrl_q    <= '0;
      mem_we    <= 1'b0;
      mem_waddr <= '0;
      mem_wdata <= '0;
    end else begin
      mem_we <= 1'b0;
      if (reg_wr) begin
        case (reg_sel)
          SEL_ADDR: addr_q <= (reg_wdata < 16'(DEPTH)) ? reg_wdata[AW-1:0] : '0;
          SEL_LO:   low_q  <= reg_wdata;
          SEL_HI: begin
            mem_we    <= 1'b1;
            mem_waddr <= addr_q;
            mem_wdata <= {reg_wdata, low_q};
          end
          default:  ctrl_q <= reg_wdata[1:0];
        endcase
      end
      if (hi_acc && autoinc) addr_q <= addr_nx;
    end
  end

  assign mem_raddr = addr_q;
  assign mem_sel   = ctrl_q[1];

  always_comb begin
    case (reg_sel)
      SEL_ADDR: reg_rdata = 16'(addr_q);
      SEL_LO:   reg_rdata = mem_rdata[15:0];
      SEL_HI:   reg_rdata = mem_rdata[31:16];
      default:  reg_rdata = {14'b0, ctrl_q};
    endcase
  end

  function automatic logic [15:0] pick(input logic [SAMPLE_W-1:0] x, input logic rnd);
    logic [SAMPLE_W:0] s;
    s = {x[SAMPLE_W-1], x} + (rnd ? ((SAMPLE_W+1)'(1) << (DROP - 1)) : '0);
    if (s[SAMPLE_W] != s[SAMPLE_W-1]) pick = 16'h7FFF;
    else pick = s[SAMPLE_W-1:DROP];
  endfunction

  assign cap_word = cap_mag_mode ? {15'b0, cap_mag[15], 1'b0, cap_mag[14:0]}
                                 : {pick(cap_i, cap_round), pick(cap_q, cap_round)};
endmodule

// File: rtl/capmem_port_chk.sv
module capmem_port_chk #(
  parameter int DEPTH = 1000,
  parameter int AW    = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_wr,
  input logic          reg_rd,
  input logic [1:0]    reg_sel,
  input logic [15:0]   reg_wdata,
  input logic          mem_we,
  input logic [AW-1:0] mem_waddr,
  input logic [31:0]   mem_wdata,
  input logic [AW-1:0] addr_q,
  input logic [1:0]    ctrl_q
);
  assert_commit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_sel == 2'd2) |=> (mem_we && mem_wdata[31:16] == $past(reg_wdata)
                                     && mem_waddr == $past(addr_q)));

  assert_we_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> $past(reg_wr && reg_sel == 2'd2));

  assert_low_keeps_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((reg_wr || reg_rd) && reg_sel == 2'd1) |=> $stable(addr_q));

  assert_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((reg_wr || reg_rd) && reg_sel == 2'd2 && ctrl_q[0] && 32'(addr_q) != DEPTH - 1)
      |=> 32'(addr_q) == 32'($past(addr_q)) + 1);

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((reg_wr || reg_rd) && reg_sel == 2'd2 && !ctrl_q[0]) |=> $stable(addr_q));

  assert_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((reg_wr || reg_rd) && reg_sel == 2'd2 && ctrl_q[0] && 32'(addr_q) == DEPTH - 1)
      |=> addr_q == '0);

  assert_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    32'(addr_q) < DEPTH);

  assert_read_no_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && !reg_wr) |=> !mem_we);
endmodule

bind capmem_port capmem_port_chk #(.DEPTH(DEPTH), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_sel(reg_sel),
  .reg_wdata(reg_wdata), .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
  .addr_q(addr_q), .ctrl_q(ctrl_q)
);

// File: tb/capmem_port_bench.sv
module capmem_port_bench;
  localparam int DEPTH = 1000;
  localparam int AW = $clog2(DEPTH);

  logic clk = 0, rst_n = 0;
  logic reg_wr = 0, reg_rd = 0;
  logic [1:0] reg_sel = 0;
  logic [15:0] reg_wdata = 0, reg_rdata;
  logic [AW-1:0] mem_raddr, mem_waddr;
  logic [31:0] mem_rdata, mem_wdata, cap_word;
  logic mem_we, mem_sel;
  logic cap_mag_mode = 0, cap_round = 0;
  logic [19:0] cap_i = 0, cap_q = 0;
  logic [15:0] cap_mag = 0;

  always #2 clk = ~clk;

  capmem_port u_capmem_port (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_raddr(mem_raddr),
    .mem_rdata(mem_rdata), .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
    .mem_sel(mem_sel), .cap_mag_mode(cap_mag_mode), .cap_round(cap_round),
    .cap_i(cap_i), .cap_q(cap_q), .cap_mag(cap_mag), .cap_word(cap_word)
  );

  logic [31:0] m0 [DEPTH];
  logic [31:0] m1 [DEPTH];
  logic [31:0] s0 [DEPTH];
  logic [31:0] s1 [DEPTH];

  always @(posedge clk)
    if (mem_we) begin
      if (mem_sel) m1[mem_waddr] <= mem_wdata;
      else m0[mem_waddr] <= mem_wdata;
    end
  assign mem_rdata = mem_sel ? m1[mem_raddr] : m0[mem_raddr];

  int checks = 0, errors = 0;
  bit done = 0;
  int e_addr = 0;
  logic [15:0] e_low = 0;
  bit e_auto = 0, e_msel = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic int next_addr(input int a);
    return (a == DEPTH - 1) ? 0 : a + 1;
  endfunction

  function automatic logic [15:0] half(input logic [19:0] x, input bit rnd);
    int v;
    v = int'($signed(x));
    if (rnd) v = v + 8;
    v = v >>> 4;
    if (v > 32767) v = 32767;
    return 16'(v);
  endfunction

  function automatic logic [31:0] exp_cap(input bit mm, input bit rnd, input logic [19:0] i,
                                          input logic [19:0] q, input logic [15:0] m);
    if (mm) return {16'(m[15]), 16'(m[14:0])};
    return {half(i, rnd), half(q, rnd)};
  endfunction

  task automatic wr(input logic [1:0] sel, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
    if (sel == 2) begin
      chk("R3 commit we", 32'(mem_we), 1);
      chk("R3 commit addr", 32'(mem_waddr), 32'(e_addr));
      chk("R3 commit data", mem_wdata, {d, e_low});
      if (e_msel) s1[e_addr] = {d, e_low}; else s0[e_addr] = {d, e_low};
      if (e_auto) e_addr = next_addr(e_addr);
    end else begin
      chk("R3 no commit", 32'(mem_we), 0);
      if (sel == 0) e_addr = (d < DEPTH) ? int'(d) : 0;
      else if (sel == 1) e_low = d;
      else begin e_auto = d[0]; e_msel = d[1]; end
    end
    @(negedge clk);
    chk("R3 single pulse", 32'(mem_we), 0);
  endtask

  task automatic rd(input logic [1:0] sel, input string req);
    logic [31:0] w;
    @(negedge clk);
    reg_rd = 1; reg_sel = sel;
    #1;
    w = e_msel ? s1[e_addr] : s0[e_addr];
    case (sel)
      2'd0: chk({req, " addr"}, 32'(reg_rdata), 32'(e_addr));
      2'd1: chk({req, " low"}, 32'(reg_rdata), 32'(w[15:0]));
      2'd2: chk({req, " high"}, 32'(reg_rdata), 32'(w[31:16]));
      default: chk({req, " ctrl"}, 32'(reg_rdata), {30'b0, e_msel, e_auto});
    endcase
    chk("R8 mem_sel", 32'(mem_sel), 32'(e_msel));
    @(negedge clk);
    reg_rd = 0;
    chk("R7 read no write", 32'(mem_we), 0);
    if (sel == 2 && e_auto) e_addr = next_addr(e_addr);
  endtask

  task automatic cap(input bit mm, input bit rnd, input logic [19:0] i, input logic [19:0] q,
                     input logic [15:0] m, input string req);
    @(negedge clk);
    cap_mag_mode = mm; cap_round = rnd; cap_i = i; cap_q = q; cap_mag = m;
    #1;
    chk(req, cap_word, exp_cap(mm, rnd, i, q, m));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int unused;
    unused = $urandom(32'd7411);
    for (int k = 0; k < DEPTH; k++) begin
      m0[k] = 32'(k) * 32'h9E3779B1; m1[k] = ~(32'(k) * 32'h85EBCA6B);
      s0[k] = m0[k]; s1[k] = m1[k];
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 we after reset", 32'(mem_we), 0);
    chk("R1 mem_sel after reset", 32'(mem_sel), 0);
    rd(2'd0, "R1");
    rd(2'd3, "R1");
    wr(2'd2, 16'hABCD);
    chk("R1 cleared low half", m0[0], 32'hABCD_0000);
    rd(2'd0, "R5 no step");

    wr(2'd0, 16'd1234);
    rd(2'd0, "R2 clamp");
    wr(2'd0, 16'd17);
    rd(2'd0, "R2 load");

    wr(2'd3, 16'h0001);
    wr(2'd1, 16'h1111);
    rd(2'd0, "R4 low no step");
    wr(2'd2, 16'h2222);
    rd(2'd0, "R4 step");
    wr(2'd0, 16'(DEPTH - 1));
    wr(2'd1, 16'h5A5A);
    wr(2'd2, 16'hA5A5);
    rd(2'd0, "R6 wrap write");
    wr(2'd0, 16'(DEPTH - 1));
    rd(2'd1, "R7");
    rd(2'd2, "R7");
    rd(2'd0, "R6 wrap read");
    wr(2'd3, 16'h0003);
    wr(2'd0, 16'd5);
    wr(2'd1, 16'hBEEF);
    wr(2'd2, 16'hCAFE);
    chk("R8 memory 1 written", m1[5], 32'hCAFE_BEEF);
    chk("R8 memory 0 untouched", m0[5], s0[5]);
    wr(2'd3, 16'h0002);
    wr(2'd0, 16'd5);
    rd(2'd2, "R5");
    rd(2'd2, "R5");
    rd(2'd0, "R5 held");

    for (int n = 0; n < 600; n++) begin
      int op;
      op = int'($urandom % 8);
      case (op)
        0: wr(2'd0, 16'($urandom % (DEPTH + 40)));
        1: wr(2'd3, 16'($urandom));
        2, 3: wr(2'd1, 16'($urandom));
        4: wr(2'd2, 16'($urandom));
        5: rd(2'd1, "R7 random");
        6: rd(2'd2, "R7 random");
        default: rd(2'($urandom % 4), "R2 random");
      endcase
    end

    cap(0, 0, 20'h12345, 20'hFEDCB, 0, "R9 truncate");
    cap(0, 1, 20'h7FFF7, 20'h00008, 0, "R10 round below limit");
    cap(0, 1, 20'h7FFF8, 20'h7FFFF, 0, "R10 saturate");
    cap(0, 0, 20'h7FFFF, 20'h80000, 0, "R9 extremes");
    cap(0, 1, 20'h80000, 20'hFFFF7, 0, "R10 negative");
    cap(1, 0, 0, 0, 16'h8001, "R11 top bit");
    cap(1, 1, 0, 0, 16'h7FFF, "R11 low bits");
    for (int n = 0; n < 300; n++)
      cap(1'($urandom), 1'($urandom), 20'($urandom), 20'($urandom), 16'($urandom),
          "R9 R10 R11 random");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule